// File: doc/BRIEF.md
# Multi-Source Reset Sequence Manager

This block merges four reset causes into one sequenced internal reset and controls an open-drain reset pin. The causes are an external pin (asynchronous, active low), a low-voltage detect flag, a one-cycle watchdog underflow pulse and a one-cycle illegal-opcode pulse. Each reset runs through three phases in a fixed order. First comes an active phase whose length depends on the cause. Then a stabilisation delay of 256 clocks holds the pin low. Last, a two-cycle fetch presents the reset vector addresses FFFEh and FFFFh. When the PLL is enabled, a start-up wait is placed between the delay and the fetch.

The external pin passes through a two-flop synchroniser and a width filter, so short glitches are rejected. While the block drives the pin itself, the filter is held clear, so the block cannot trigger itself from its own drive. A new cause that arrives at any point restarts the sequence from the active phase. Status outputs report the run, delay and fetch phases and the pin drive.

Top module: `rstseq_top`

## Requirements
- R1: At power-on reset (porN low) the block is in the delay phase with the pin driven low. After porN rises it stays in the delay phase for DELAY_CYCLES (256) cycles, then fetches for 2 cycles, then sets inRun to 1.
- R2: The fetch phase lasts 2 cycles with inFetch at 1. fetchAddr is FFFFh-1 (FFFEh) in the first cycle, FFFFh in the second, and 0 in all other phases.
- R3: The external source fires only after the synchronised pin (two flops) has been low for MIN_IN_CYCLES (4) consecutive cycles. A low lasting 3 cycles leaves inRun at 1 and pinDriveLow at 0.
- R4: In the active phase of an external reset the pin is not driven. That phase ends on the first clock edge at which the synchronised pin reads high, and the delay phase starts on that edge.
- R5: In the active phase of a low-voltage reset the pin is driven low. The phase lasts as long as lvdFlag is 1 and moves to the delay phase on the first edge that samples lvdFlag at 0.
- R6: A watchdog or illegal-opcode pulse gives an active phase of MIN_OUT_CYCLES (16) cycles with the pin low, followed by the delay phase. The pin is therefore low for 16+256 cycles in total.
- R7: pinDriveLow is 1 in every cycle of the delay phase and of the PLL wait, whatever the source.
- R8: If pllEnable is 1 on the last cycle of the delay phase, a PLL wait of PLL_CYCLES (32) cycles, with the pin still low, comes before the fetch.
- R9: A new cause in the active, delay, PLL wait or fetch phase restarts the active phase on the next edge. The external pin is ignored in any cycle in which pinDriveLow is 1.
- R10: When several causes are present in the same cycle, the cause that sets the active-phase length is chosen in this order: low-voltage first, then external, then watchdog, then illegal-opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| extPinIn | input | 1 | Level read from the reset pin, asynchronous |
| lvdFlag | input | 1 | Low-voltage detect level |
| wdgUnderflow | input | 1 | Watchdog underflow pulse |
| illegalOp | input | 1 | Illegal-opcode pulse |
| pllEnable | input | 1 | Adds a PLL start-up wait after the delay phase |
| pinDriveLow | output | 1 | Enables the open-drain pull-down on the reset pin |
| inRun | output | 1 | Normal running, no reset phase active |
| inDelay | output | 1 | Stabilisation delay phase |
| inFetch | output | 1 | Vector fetch phase |
| fetchAddr | output | 16 | Vector address during fetch, else 0 |

## Verification
Every cause is sampled on a rising edge, and the phase outputs change just after that same edge. A pulse applied for one cycle is therefore already seen as the active phase at the following falling edge. An external low lasting L cycles fires on the sixth edge after it starts and leaves L-3 active cycles, because of two synchroniser stages and a four-count filter. The bench keeps a behavioural countdown model that it updates on each rising edge and compares with all outputs on each falling edge. Directed checks count pin-low and busy cycles from a known falling edge, using the figures 272, 304, 257 and 261 that follow from these latencies.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    PH_RUN, PH_ACTIVE, PH_DELAY, PH_PLL, PH_FETCH
  } phase_e;

  typedef enum logic [1:0] {
    SRC_EXT, SRC_LVD, SRC_WDG, SRC_ILL
  } src_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic maskExt;
  } seq_strobe_t;
endpackage

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int MIN_IN_CYCLES = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 9
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extPinIn,
  input  seq_strobe_t       strobe,
  output logic              extTrig,
  output logic              extHigh,
  output logic [CNT_W-1:0]  phaseCnt
);
  localparam int LOW_W = $clog2(MIN_IN_CYCLES + 1);
  localparam logic [LOW_W-1:0] LOW_MAX  = LOW_W'(MIN_IN_CYCLES);
  localparam logic [LOW_W-1:0] LOW_TRIG = LOW_W'(MIN_IN_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [LOW_W-1:0]       lowCnt;
  logic                   pinSync;

  // synchroniser chain, one flop per stage
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= extPinIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) syncQ[s] <= 1'b1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // width filter: consecutive low samples, saturating
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               lowCnt <= '0;
    else if (strobe.maskExt) lowCnt <= '0;
    else if (!pinSync)       lowCnt <= (lowCnt == LOW_MAX) ? lowCnt : lowCnt + 1'b1;
    else                     lowCnt <= '0;
  end

  assign extTrig = !strobe.maskExt && !pinSync && (lowCnt == LOW_TRIG);
  assign extHigh = pinSync;

  // shared phase counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              phaseCnt <= '0;
    else if (strobe.cntClr) phaseCnt <= '0;
    else if (strobe.cntInc) phaseCnt <= phaseCnt + 1'b1;
  end

  // R9: a masked cycle leaves the filter empty
  a_r9_mask_clears: assert property (@(posedge clk) disable iff (!porN)
    $past(strobe.maskExt) |-> lowCnt == '0);
  // R3: the filter never counts past its threshold
  a_r3_filter_bound: assert property (@(posedge clk) disable iff (!porN)
    lowCnt <= LOW_MAX);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int          MIN_OUT_CYCLES = 16,
  parameter int          DELAY_CYCLES   = 256,
  parameter int          PLL_CYCLES     = 32,
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] RESET_VECTOR   = 16'hFFFE,
  parameter int          CNT_W          = 9
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extTrig,
  input  logic              extHigh,
  input  logic              lvdFlag,
  input  logic              wdgUnderflow,
  input  logic              illegalOp,
  input  logic              pllEnable,
  input  logic [CNT_W-1:0]  phaseCnt,
  output seq_strobe_t       strobe,
  output logic              pinDriveLow,
  output logic              inRun,
  output logic              inDelay,
  output logic              inFetch,
  output logic [ADDR_W-1:0] fetchAddr
);
  localparam logic [CNT_W-1:0] OUT_LAST   = CNT_W'(MIN_OUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYCLES - 1);
  localparam logic [CNT_W-1:0] PLL_LAST   = CNT_W'(PLL_CYCLES - 1);
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(1);

  phase_e phaseQ, phaseN;
  src_e   srcQ, srcN;
  logic   anyTrig, activeDone;

  assign anyTrig = lvdFlag | extTrig | wdgUnderflow | illegalOp;

  always_comb begin
    unique case (srcQ)
      SRC_LVD: activeDone = !lvdFlag;
      SRC_EXT: activeDone = extHigh;
      default: activeDone = (phaseCnt == OUT_LAST);
    endcase
  end

  always_comb begin
    phaseN        = phaseQ;
    srcN          = srcQ;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    if (anyTrig) begin
      phaseN        = PH_ACTIVE;
      strobe.cntClr = 1'b1;
      if (lvdFlag)           srcN = SRC_LVD;
      else if (extTrig)      srcN = SRC_EXT;
      else if (wdgUnderflow) srcN = SRC_WDG;
      else                   srcN = SRC_ILL;
    end else begin
      unique case (phaseQ)
        PH_ACTIVE: begin
          if (activeDone) begin phaseN = PH_DELAY; strobe.cntClr = 1'b1; end
          else strobe.cntInc = 1'b1;
        end
        PH_DELAY: begin
          if (phaseCnt == DELAY_LAST) begin
            phaseN = pllEnable ? PH_PLL : PH_FETCH;
            strobe.cntClr = 1'b1;
          end else strobe.cntInc = 1'b1;
        end
        PH_PLL: begin
          if (phaseCnt == PLL_LAST) begin phaseN = PH_FETCH; strobe.cntClr = 1'b1; end
          else strobe.cntInc = 1'b1;
        end
        PH_FETCH: begin
          if (phaseCnt == FETCH_LAST) begin phaseN = PH_RUN; strobe.cntClr = 1'b1; end
          else strobe.cntInc = 1'b1;
        end
        default: phaseN = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phaseQ <= PH_DELAY;
      srcQ   <= SRC_EXT;
    end else begin
      phaseQ <= phaseN;
      srcQ   <= srcN;
    end
  end

  assign pinDriveLow   = (phaseQ == PH_ACTIVE && srcQ != SRC_EXT) ||
                         phaseQ == PH_DELAY || phaseQ == PH_PLL;
  assign strobe.maskExt = pinDriveLow;
  assign inRun   = (phaseQ == PH_RUN);
  assign inDelay = (phaseQ == PH_DELAY);
  assign inFetch = (phaseQ == PH_FETCH);
  assign fetchAddr = inFetch ? {RESET_VECTOR[ADDR_W-1:1], phaseCnt[0]} : '0;

  // R1: running stays running without a cause
  a_r1_run_hold: assert property (@(posedge clk) disable iff (!porN)
    (phaseQ == PH_RUN && !anyTrig) |=> phaseQ == PH_RUN);
  // R2: low vector byte is followed by the high one
  a_r2_vec_order: assert property (@(posedge clk) disable iff (!porN)
    (inFetch && phaseCnt == '0 && !anyTrig) |=> (inFetch && fetchAddr == (RESET_VECTOR | 16'h1)));
  // R6: internal causes keep the active phase for the minimum width
  a_r6_min_out: assert property (@(posedge clk) disable iff (!porN)
    (phaseQ == PH_ACTIVE && (srcQ == SRC_WDG || srcQ == SRC_ILL) &&
     phaseCnt != OUT_LAST && !anyTrig) |=> (phaseQ == PH_ACTIVE && pinDriveLow));
  // R7: fetch is entered only from a cycle with the pin held low
  a_r7_fetch_after_low: assert property (@(posedge clk) disable iff (!porN)
    (inFetch && $past(phaseQ) != PH_FETCH) |-> $past(pinDriveLow));
  // R8: PLL wait follows the delay when enabled
  a_r8_pll_wait: assert property (@(posedge clk) disable iff (!porN)
    (inDelay && phaseCnt == DELAY_LAST && pllEnable && !anyTrig) |=> phaseQ == PH_PLL);
  // R9: any cause restarts the active phase
  a_r9_restart: assert property (@(posedge clk) disable iff (!porN)
    anyTrig |=> (phaseQ == PH_ACTIVE && phaseCnt == '0));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int          MIN_IN_CYCLES  = 4,
  parameter int          MIN_OUT_CYCLES = 16,
  parameter int          DELAY_CYCLES   = 256,
  parameter int          PLL_CYCLES     = 32,
  parameter int          SYNC_STAGES    = 2,
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] RESET_VECTOR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extPinIn,
  input  logic              lvdFlag,
  input  logic              wdgUnderflow,
  input  logic              illegalOp,
  input  logic              pllEnable,
  output logic              pinDriveLow,
  output logic              inRun,
  output logic              inDelay,
  output logic              inFetch,
  output logic [ADDR_W-1:0] fetchAddr
);
  localparam int MAX_A = (DELAY_CYCLES > PLL_CYCLES) ? DELAY_CYCLES : PLL_CYCLES;
  localparam int MAX_V = (MAX_A > MIN_OUT_CYCLES) ? MAX_A : MIN_OUT_CYCLES;
  localparam int CNT_W = $clog2(MAX_V + 1);

  seq_strobe_t      strobe;
  logic             extTrig, extHigh;
  logic [CNT_W-1:0] phaseCnt;

  rstseq_datapath #(
    .MIN_IN_CYCLES(MIN_IN_CYCLES), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) datapath_i (
    .clk(clk), .porN(porN), .extPinIn(extPinIn), .strobe(strobe),
    .extTrig(extTrig), .extHigh(extHigh), .phaseCnt(phaseCnt)
  );

  rstseq_ctrl #(
    .MIN_OUT_CYCLES(MIN_OUT_CYCLES), .DELAY_CYCLES(DELAY_CYCLES),
    .PLL_CYCLES(PLL_CYCLES), .ADDR_W(ADDR_W), .RESET_VECTOR(RESET_VECTOR), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .porN(porN), .extTrig(extTrig), .extHigh(extHigh),
    .lvdFlag(lvdFlag), .wdgUnderflow(wdgUnderflow), .illegalOp(illegalOp),
    .pllEnable(pllEnable), .phaseCnt(phaseCnt), .strobe(strobe),
    .pinDriveLow(pinDriveLow), .inRun(inRun), .inDelay(inDelay),
    .inFetch(inFetch), .fetchAddr(fetchAddr)
  );
endmodule

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_IN  = 4;
  localparam int MIN_OUT = 16;
  localparam int DELAY   = 256;
  localparam int PLLW    = 32;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extLow = 1'b0;
  logic lvdFlag = 1'b0, wdgUnderflow = 1'b0, illegalOp = 1'b0, pllEnable = 1'b0;
  logic pinDriveLow, inRun, inDelay, inFetch;
  logic [15:0] fetchAddr;
  logic extPinIn;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain pin with pull-up
  assign extPinIn = !(extLow || pinDriveLow);

  rstseq_top dut_i (
    .clk(clk), .porN(porN), .extPinIn(extPinIn), .lvdFlag(lvdFlag),
    .wdgUnderflow(wdgUnderflow), .illegalOp(illegalOp), .pllEnable(pllEnable),
    .pinDriveLow(pinDriveLow), .inRun(inRun), .inDelay(inDelay),
    .inFetch(inFetch), .fetchAddr(fetchAddr)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 run, 1 active, 2 delay, 3 pll, 4 fetch
  // source 0 ext, 1 lvd, 2 wdg, 3 illegal
  int mPhase, mSrc, mRem, mLow;
  bit mS1, mS2;

  function automatic bit mDrv();
    return (mPhase == 1 && mSrc != 0) || mPhase == 2 || mPhase == 3;
  endfunction

  always @(posedge clk or negedge porN) begin : model
    bit drv, pin, eTrig, trig;
    if (!porN) begin
      mPhase = 2; mRem = DELAY; mSrc = 0; mS1 = 1; mS2 = 1; mLow = 0;
    end else begin
      drv   = mDrv();
      pin   = !(extLow || drv);
      eTrig = !drv && !mS2 && (mLow == MIN_IN - 1);
      trig  = lvdFlag || eTrig || wdgUnderflow || illegalOp;
      if (trig) begin
        mPhase = 1; mRem = MIN_OUT;
        mSrc = lvdFlag ? 1 : eTrig ? 0 : wdgUnderflow ? 2 : 3;
      end else begin
        case (mPhase)
          1: begin
            if (mSrc == 1) begin
              if (!lvdFlag) begin mPhase = 2; mRem = DELAY; end
            end else if (mSrc == 0) begin
              if (mS2) begin mPhase = 2; mRem = DELAY; end
            end else if (mRem == 1) begin mPhase = 2; mRem = DELAY; end
            else mRem--;
          end
          2: if (mRem == 1) begin
               if (pllEnable) begin mPhase = 3; mRem = PLLW; end
               else begin mPhase = 4; mRem = 2; end
             end else mRem--;
          3: if (mRem == 1) begin mPhase = 4; mRem = 2; end else mRem--;
          4: if (mRem == 1) mPhase = 0; else mRem--;
          default: ;
        endcase
      end
      if (drv) mLow = 0;
      else if (!mS2) mLow = (mLow < MIN_IN) ? mLow + 1 : mLow;
      else mLow = 0;
      mS2 = mS1; mS1 = pin;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checkEq("R1 inRun", int'(inRun), int'(mPhase == 0));
      checkEq("R1 inDelay", int'(inDelay), int'(mPhase == 2));
      checkEq("R2 inFetch", int'(inFetch), int'(mPhase == 4));
      checkEq("R2 fetchAddr", int'(fetchAddr),
              (mPhase == 4) ? ((mRem == 2) ? 32'hFFFE : 32'hFFFF) : 0);
      checkEq("R7 pinDriveLow", int'(pinDriveLow), int'(mDrv()));
    end
  end

  // counts from the current falling edge until running
  task automatic measure(output int lowN, output int busyN, output int delayN);
    lowN = 0; busyN = 0; delayN = 0;
    while (!inRun && busyN < 2000) begin
      lowN += int'(pinDriveLow);
      delayN += int'(inDelay);
      busyN++;
      @(negedge clk);
    end
  endtask

  task automatic pulseWdg();
    @(negedge clk) wdgUnderflow = 1'b1;
    @(negedge clk) wdgUnderflow = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    int lowN, busyN, delayN;
    // R1 reset state
    repeat (3) @(negedge clk);
    checkEq("R1 reset inRun", int'(inRun), 0);
    checkEq("R1 reset pin low", int'(pinDriveLow), 1);
    porN = 1'b1;
    measure(lowN, busyN, delayN);
    checkEq("R1 power-up delay", delayN, DELAY);
    checkEq("R1 power-up busy", busyN, DELAY + 2);
    settle();

    // R6 watchdog
    pulseWdg();
    measure(lowN, busyN, delayN);
    checkEq("R6 wdg pin low", lowN, MIN_OUT + DELAY);
    checkEq("R6 wdg busy", busyN, MIN_OUT + DELAY + 2);
    settle();

    // R6 illegal opcode
    @(negedge clk) illegalOp = 1'b1;
    @(negedge clk) illegalOp = 1'b0;
    measure(lowN, busyN, delayN);
    checkEq("R6 illegal pin low", lowN, MIN_OUT + DELAY);
    settle();

    // R8 PLL wait
    pllEnable = 1'b1;
    pulseWdg();
    measure(lowN, busyN, delayN);
    checkEq("R8 pll pin low", lowN, MIN_OUT + DELAY + PLLW);
    checkEq("R8 pll busy", busyN, MIN_OUT + DELAY + PLLW + 2);
    pllEnable = 1'b0;
    settle();

    // R5 low-voltage held 40 cycles
    @(negedge clk) lvdFlag = 1'b1;
    repeat (40) @(negedge clk);
    checkEq("R5 lvd still active", int'(pinDriveLow && !inDelay && !inRun), 1);
    lvdFlag = 1'b0;
    measure(lowN, busyN, delayN);
    checkEq("R5 lvd tail low", lowN, 1 + DELAY);
    settle();

    // R3 short external low ignored
    @(negedge clk) extLow = 1'b1;
    repeat (3) @(negedge clk);
    extLow = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R3 short low ignored inRun", int'(inRun), 1);
    checkEq("R3 short low ignored pin", int'(pinDriveLow), 0);
    settle();

    // R3 boundary: exactly the minimum width
    @(negedge clk) extLow = 1'b1;
    repeat (4) @(negedge clk);
    extLow = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R3 min width accepted", int'(inDelay), 1);
    measure(lowN, busyN, delayN);
    settle();

    // R4 external low for 10 cycles
    @(negedge clk) extLow = 1'b1;
    repeat (10) @(negedge clk);
    extLow = 1'b0;
    checkEq("R4 ext active not driven", int'(!inRun && !pinDriveLow), 1);
    measure(lowN, busyN, delayN);
    checkEq("R4 ext pin low", lowN, DELAY);
    checkEq("R4 ext busy", busyN, 3 + DELAY + 2);
    settle();

    // R9 restart during delay
    pulseWdg();
    repeat (100) @(negedge clk);
    illegalOp = 1'b1;
    @(negedge clk) illegalOp = 1'b0;
    checkEq("R9 restart from delay", int'(pinDriveLow && !inDelay), 1);
    measure(lowN, busyN, delayN);
    checkEq("R9 restart full length", lowN, MIN_OUT + DELAY);
    settle();

    // R9 restart during fetch
    pulseWdg();
    while (!inFetch) @(negedge clk);
    wdgUnderflow = 1'b1;
    @(negedge clk) wdgUnderflow = 1'b0;
    checkEq("R9 restart from fetch", int'(pinDriveLow && !inFetch), 1);
    measure(lowN, busyN, delayN);
    checkEq("R9 fetch restart length", lowN, MIN_OUT + DELAY);
    settle();

    // R9 external pin ignored while the block drives it
    pulseWdg();
    fork
      measure(lowN, busyN, delayN);
      begin
        repeat (50) @(negedge clk);
        extLow = 1'b1;
        repeat (30) @(negedge clk);
        extLow = 1'b0;
      end
    join
    checkEq("R9 ext masked", lowN, MIN_OUT + DELAY);
    settle();

    // R10 priority: low-voltage beats watchdog
    @(negedge clk) begin lvdFlag = 1'b1; wdgUnderflow = 1'b1; end
    @(negedge clk) begin lvdFlag = 1'b0; wdgUnderflow = 1'b0; end
    measure(lowN, busyN, delayN);
    checkEq("R10 lvd wins", lowN, 1 + DELAY);
    settle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule